// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block answers protection queries about a segment selector, given the two 32-bit words of the descriptor that the selector names. The caller fetches the descriptor from memory, works out whether the selector's index lay inside its descriptor table, and pulses `start` with all operands stable. One clock later the block pulses `done`. With it come a zero-flag verdict, an optional result value with its write enable, and an undefined-opcode fault indication.

There are four queries. One reads the access-rights bytes of the descriptor. One reads the segment limit, expanded to byte granularity. The other two check whether the segment can be read or written at the current privilege. Each query has its own rules for which descriptor kinds it accepts, how it treats conforming code, and whether the privilege comparison applies. The verify queries produce only the flag. The two read queries also deliver a value, sized by the operand-size input. The parameter `WIDE_SYS` decides whether the access-rights query also accepts the 32-bit task-state and call-gate system types.

Top module: `seg_query_unit`

## Requirements
- R1: While reset is held, and after it is released until the first `start`, `done`, `zf`, `res_we`, `ud_fault` and `res` are all zero.
- R2: Query codes on `op`: 0 reads access rights, 1 reads the limit, 2 verifies read access, 3 verifies write access. A `start` sampled at a clock edge produces exactly one cycle of `done` after that edge. `res_we` and `ud_fault` are high only together with `done`.
- R3: When `legacy_mode` is high at `start`, every query reports `ud_fault`=1, `zf`=0, `res_we`=0 and `res`=0.
- R4: A selector whose bits 15:2 are all zero is null. Whatever its bits 1:0 are, it gives `zf`=0 and no result write.
- R5: When `in_table` is low, the result is `zf`=0 with no write.
- R6: The privilege level of the descriptor is high-word bits 14:13 and the requester level is selector bits 1:0. Unless a rule below exempts the case, access is refused when the descriptor level is numerically below either the current level `cpl` or the requester level.
- R7: The limit query forms a 20-bit value from high-word bits 19:16 above low-word bits 15:0. When high-word bit 23 is set, the value is shifted left by 12 and the vacated 12 bits are ones. With `wide_op`=0 only the low 16 bits are returned, zero-extended.
- R8: High-word bit 12 set marks a code/data segment, and type bits 11:8 follow. A segment with type bits 11 and 10 both set is conforming code. The access-rights query and the limit query skip the privilege check for conforming code.
- R9: The access-rights value is the high word ANDed with 0x00FFFF00 when `wide_op`=1, and with 0x0000FF00 when `wide_op`=0.
- R10: Among system descriptors (bit 12 clear), the limit query accepts types 1, 2, 3, 9 and 11. The access-rights query accepts those plus types 4, 5 and 12, where 9, 11 and 12 depend on `WIDE_SYS`=1. Both queries still apply the privilege check. All other system types give `zf`=0.
- R11: The read-verify query refuses system descriptors and code without the readable bit (type bit 9). It passes readable conforming code at any privilege. Readable non-conforming code and data pass only the privilege check. It never writes a result.
- R12: The write-verify query refuses system descriptors and all code (type bit 11 set). It passes data with the writable bit (type bit 9) only if the privilege check passes, and never writes a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Evaluate the operands presented this cycle |
| op | input | 2 | Query code |
| sel | input | 16 | Segment selector |
| desc_lo | input | 32 | Descriptor low word |
| desc_hi | input | 32 | Descriptor high word |
| in_table | input | 1 | Selector index lies within its descriptor table |
| cpl | input | 2 | Current privilege level |
| legacy_mode | input | 1 | Processor is in real or virtual-8086 mode |
| wide_op | input | 1 | 32-bit operand size |
| done | output | 1 | One-cycle completion pulse |
| zf | output | 1 | Query verdict, held until the next query |
| res_we | output | 1 | Result value should be written (pulse) |
| res | output | 32 | Result value, zero when not written |
| ud_fault | output | 1 | Undefined-opcode fault (pulse) |

## Verification
The bench builds the block with its default `WIDE_SYS`=1. At that setting the 32-bit task-state types can be seen passing the limit query, and the 32-bit call gate can be seen passing the access-rights query while the limit query refuses the same descriptor. The vector table sets conforming and non-conforming code against data at several privilege combinations. Each one goes through the queries where their rules differ, with both operand sizes and both granularity settings.

// File: rtl/seg_query_unit.sv
module seg_query_unit #(
  parameter bit WIDE_SYS = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [15:0] sel,
  input  logic [31:0] desc_lo,
  input  logic [31:0] desc_hi,
  input  logic        in_table,
  input  logic [1:0]  cpl,
  input  logic        legacy_mode,
  input  logic        wide_op,
  output logic        done,
  output logic        zf,
  output logic        res_we,
  output logic [31:0] res,
  output logic        ud_fault
);
  localparam logic [1:0] Q_RIGHTS = 2'd0;
  localparam logic [1:0] Q_LIMIT  = 2'd1;
  localparam logic [1:0] Q_READ   = 2'd2;
  localparam logic [1:0] Q_WRITE  = 2'd3;

  wire [1:0]  dpl      = desc_hi[14:13];
  wire        is_seg   = desc_hi[12];
  wire [3:0]  typ      = desc_hi[11:8];
  wire        is_null  = (sel[15:2] == 14'd0);
  wire        priv_ok  = (dpl >= cpl) && (dpl >= sel[1:0]);
  wire        conf     = is_seg & typ[3] & typ[2];
  wire [19:0] lim_raw  = {desc_hi[19:16], desc_lo[15:0]};
  wire [31:0] lim_full = desc_hi[23] ? {lim_raw, 12'hFFF} : {12'h000, lim_raw};

  logic ar_sys_ok, lim_sys_ok, pass, wr;
  logic [31:0] val;

  always_comb begin
    case (typ)
      4'h1, 4'h2, 4'h3, 4'h4, 4'h5: ar_sys_ok = 1'b1;
      4'h9, 4'hB, 4'hC:             ar_sys_ok = WIDE_SYS;
      default:                      ar_sys_ok = 1'b0;
    endcase
    case (typ)
      4'h1, 4'h2, 4'h3, 4'h9, 4'hB: lim_sys_ok = 1'b1;
      default:                      lim_sys_ok = 1'b0;
    endcase
  end

  always_comb begin
    pass = 1'b0;
    wr   = 1'b0;
    val  = 32'h0;
    case (op)
      Q_RIGHTS: begin
        pass = is_seg ? (conf | priv_ok) : (ar_sys_ok & priv_ok);
        wr   = 1'b1;
        val  = wide_op ? (desc_hi & 32'h00FFFF00) : {16'h0, desc_hi[15:8], 8'h00};
      end
      Q_LIMIT: begin
        pass = is_seg ? (conf | priv_ok) : (lim_sys_ok & priv_ok);
        wr   = 1'b1;
        val  = wide_op ? lim_full : {16'h0, lim_full[15:0]};
      end
      Q_READ:  pass = is_seg & (typ[3] ? (typ[1] & (typ[2] | priv_ok)) : priv_ok);
      Q_WRITE: pass = is_seg & ~typ[3] & typ[1] & priv_ok;
      default: pass = 1'b0;
    endcase
  end

  wire ok = ~legacy_mode & ~is_null & in_table & pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      zf       <= 1'b0;
      res_we   <= 1'b0;
      res      <= 32'h0;
      ud_fault <= 1'b0;
    end else begin
      done     <= start;
      res_we   <= start & ok & wr;
      ud_fault <= start & legacy_mode;
      if (start) begin
        zf  <= ok;
        res <= (ok && wr) ? val : 32'h0;
      end
    end
  end

  // R2
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R2
  done_only_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  // R2
  we_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we || ud_fault) |-> done);
  // R3
  ud_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> (!zf && !res_we && res == 32'h0));
  // R4
  null_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sel[15:2] == 14'd0) |=> (!zf && !res_we));
  // R5
  out_of_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_table) |=> (!zf && !res_we));
  // R11
  verify_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op[1]) |=> !res_we);
endmodule

// File: tb/tb_seg_query_unit.sv
module tb_seg_query_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start, in_table, legacy_mode, wide_op;
  logic [1:0]  op, cpl;
  logic [15:0] sel;
  logic [31:0] desc_lo, desc_hi;
  logic        done, zf, res_we, ud_fault;
  logic [31:0] res;

  seg_query_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sel(sel),
    .desc_lo(desc_lo), .desc_hi(desc_hi), .in_table(in_table), .cpl(cpl),
    .legacy_mode(legacy_mode), .wide_op(wide_op), .done(done), .zf(zf),
    .res_we(res_we), .res(res), .ud_fault(ud_fault)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] sel;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        tab;
    logic [1:0]  cpl;
    logic        leg;
    logic        wide;
    logic        ezf;
    logic        ewe;
    logic [31:0] eres;
    logic        eud;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h0010, 32'h0000FFFF, 32'h00CFF200, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h00CFF200, 1'b0, 4'd9},  // R9
    '{2'd0, 16'h0010, 32'h0000FFFF, 32'h00CFF200, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000F200, 1'b0, 4'd9},  // R9
    '{2'd1, 16'h0010, 32'h0000FFFF, 32'h00CFF200, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFFFFFF, 1'b0, 4'd7},  // R7
    '{2'd1, 16'h0010, 32'h0000FFFF, 32'h00CFF200, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000FFFF, 1'b0, 4'd7},  // R7
    '{2'd1, 16'h0010, 32'h00001234, 32'h0045F200, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h00051234, 1'b0, 4'd7},  // R7
    '{2'd1, 16'h0010, 32'h0000FFFF, 32'h00409200, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'd6},  // R6
    '{2'd0, 16'h0012, 32'h0000FFFF, 32'h0040B200, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'd6},  // R6
    '{2'd0, 16'h0011, 32'h0000FFFF, 32'h0040B200, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0040B200, 1'b0, 4'd6},  // R6
    '{2'd1, 16'h0013, 32'h00000FFF, 32'h00409E00, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 32'h00000FFF, 1'b0, 4'd8},  // R8
    '{2'd0, 16'h0013, 32'h00000FFF, 32'h00409E00, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 32'h00409E00, 1'b0, 4'd8},  // R8
    '{2'd0, 16'h0013, 32'h00000FFF, 32'h00409A00, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'd8},  // R8
    '{2'd1, 16'h0010, 32'h00000067, 32'h0000E200, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h00000067, 1'b0, 4'd10}, // R10
    '{2'd1, 16'h0010, 32'h00000067, 32'h0000EC00, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'd10}, // R10
    '{2'd0, 16'h0010, 32'h00000067, 32'h0000EC00, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000EC00, 1'b0, 4'd10}, // R10
    '{2'd0, 16'h0010, 32'h00000067, 32'h0000E500, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000E500, 1'b0, 4'd10}, // R10
    '{2'd0, 16'h0010, 32'h00000067, 32'h0000E000, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'd10}, // R10
    '{2'd1, 16'h0010, 32'h00000068, 32'h0000EB00, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h00000068, 1'b0, 4'd10}, // R10
    '{2'd2, 16'h0010, 32'h00000067, 32'h0000E200, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'd11}, // R11
    '{2'd2, 16'h0010, 32'h0000FFFF, 32'h0040F800, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'd11}, // R11
    '{2'd2, 16'h0013, 32'h0000FFFF, 32'h00409E00, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 32'h00000000, 1'b0, 4'd11}, // R11
    '{2'd2, 16'h0013, 32'h0000FFFF, 32'h00409A00, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'd11}, // R11
    '{2'd2, 16'h0013, 32'h0000FFFF, 32'h00CFF200, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 32'h00000000, 1'b0, 4'd11}, // R11
    '{2'd3, 16'h0013, 32'h0000FFFF, 32'h00CFF200, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 32'h00000000, 1'b0, 4'd12}, // R12
    '{2'd3, 16'h0013, 32'h0000FFFF, 32'h00CFF000, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'd12}, // R12
    '{2'd3, 16'h0010, 32'h0000FFFF, 32'h0040FA00, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'd12}, // R12
    '{2'd3, 16'h0010, 32'h0000FFFF, 32'h00409200, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'd12}, // R12
    '{2'd0, 16'h0003, 32'h0000FFFF, 32'h00CFF200, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'd4},  // R4
    '{2'd1, 16'h0010, 32'h0000FFFF, 32'h00CFF200, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 4'd5},  // R5
    '{2'd2, 16'h0013, 32'h0000FFFF, 32'h00CFF200, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b1, 4'd3}   // R3
  };

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic check(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    op = v.op; sel = v.sel; desc_lo = v.lo; desc_hi = v.hi; in_table = v.tab;
    cpl = v.cpl; legacy_mode = v.leg; wide_op = v.wide; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 2'd0; sel = 16'h0; desc_lo = 32'h0;
    desc_hi = 32'h0; in_table = 1'b0; cpl = 2'd0; legacy_mode = 1'b0; wide_op = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({done, zf, res_we, ud_fault} == 4'b0 && res == 32'h0, "R1", "reset outputs",
          {done, zf, res_we, ud_fault, res[27:0]}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({done, zf, res_we, ud_fault} == 4'b0 && res == 32'h0, "R1", "idle after reset",
          {done, zf, res_we, ud_fault, res[27:0]}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      issue(VECS[i]);
      check(done === 1'b1, tag, "done", {31'h0, done}, 32'h1);
      check(zf === VECS[i].ezf, tag, "zf", {31'h0, zf}, {31'h0, VECS[i].ezf});
      check(res_we === VECS[i].ewe, tag, "res_we", {31'h0, res_we}, {31'h0, VECS[i].ewe});
      check(res === VECS[i].eres, tag, "res", res, VECS[i].eres);
      check(ud_fault === VECS[i].eud, tag, "ud_fault", {31'h0, ud_fault}, {31'h0, VECS[i].eud});
    end

    // R2: done is a single-cycle pulse; zf holds without a new start
    issue(VECS[0]);
    check(done === 1'b1 && zf === 1'b1, "R2", "pulse present", {30'h0, done, zf}, 32'h3);
    @(negedge clk);
    check(done === 1'b0 && res_we === 1'b0, "R2", "pulse ends", {30'h0, done, res_we}, 32'h0);
    check(zf === 1'b1 && res === 32'h00CFF200, "R2", "verdict held", res, 32'h00CFF200);
    // R2: operand changes with no start do nothing
    sel = 16'h0000; in_table = 1'b0; legacy_mode = 1'b1;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && zf === 1'b1 && ud_fault === 1'b0, "R2", "no start no change",
          {29'h0, done, zf, ud_fault}, 32'h2);
    legacy_mode = 1'b0; in_table = 1'b1;

    // R4: null selector with RPL 0 on limit query
    begin
      vec_t v;
      v = VECS[2];
      v.sel = 16'h0000;
      issue(v);
      check(zf === 1'b0 && res_we === 1'b0 && res === 32'h0, "R4", "null limit query",
            res, 32'h0);
      // R3: legacy mode on the access-rights query
      v = VECS[0];
      v.leg = 1'b1;
      issue(v);
      check(ud_fault === 1'b1 && zf === 1'b0 && res_we === 1'b0, "R3", "legacy rights query",
            {29'h0, ud_fault, zf, res_we}, 32'h4);
    end

    finish_run();
  end
endmodule